// File: doc/BRIEF.md
# Multi-Mode 16-bit Counter/Timer

This block is a 16-bit counter with a writable preset and one of five operating modes chosen by `mode_sel`. In the four down-counting modes the counter starts from the preset and steps down on a mode-specific stimulus. The stimulus is a reference tick for the rate and delay modes, a rising edge of an external event line in event mode, and a per-character strobe from a serial channel in character mode. When the count runs out the block raises a one-cycle terminal-count pulse. In character mode it also raises a frame-end pulse, which a transfer engine can use to close a frame. In rate mode the block reloads itself and drives a clock-enable output, either as a square wave or as single-cycle strobes, that can pace a receiver or a transmitter.

In measurement mode the counter counts up instead. It waits for a transition on the serial input, counts reference ticks until the next transition, and then latches that length into a capture register. If the length does not fit in 16 bits, the count saturates and an overflow flag is set.

Top module: `mf_counter_timer`

## Requirements
- R1: After reset, count, running, tc_pulse, frame_end, clk_en, cap_value, cap_valid and cap_ovf are all zero. A preset_wr pulse stores preset_data. A start pulse loads the stored preset into count (zero in measurement mode), sets running, and clears cap_valid, cap_ovf and clk_en. A preset written in the same cycle as start takes effect only on the next start.
- R2: A stop pulse clears running. While running is low, count holds its value whatever arrives on tick_in, evt_in, char_done or ser_in.
- R3: Rate mode (mode_sel=0) counts one step down per cycle with tick_in high. A tick that arrives while count is 0 or 1 raises tc_pulse for one cycle and reloads the preset instead of stepping down. With preset N≥1, terminal counts therefore come every N ticks.
- R4: In rate mode with pulse_sel=0, clk_en toggles at each terminal count. With pulse_sel=1, clk_en is high only in the cycle that tc_pulse is high. In every mode other than rate, clk_en is low.
- R5: Event mode (mode_sel=1) steps down only on a rising edge of evt_in. A held high level and a falling edge have no effect, and neither does tick_in. Terminal count and reload follow the rules of R3.
- R6: Character mode (mode_sel=2) steps down on each cycle with char_done high. Its terminal count raises frame_end together with tc_pulse, and the counter reloads. No other mode raises frame_end.
- R7: Delay mode (mode_sel=3) steps down on tick_in. At terminal count it raises tc_pulse once, leaves count at 0 and clears running. Later ticks have no effect until the next start.
- R8: In measurement mode (mode_sel=4), after start the count stays at 0 until ser_in changes. From that edge, count goes up by one for each tick_in that falls strictly between that edge and the next change of ser_in. At the second edge, count is copied into cap_value, cap_valid is set and running is cleared.
- R9: In measurement mode the count stops at 0xFFFF. A tick that arrives at 0xFFFF sets cap_ovf, which stays set until the next start.
- R10: The mode_sel values 5 to 7 are idle. Start still loads the preset, but count never changes and no terminal count occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Mode: 0 rate, 1 event, 2 character, 3 delay, 4 measure |
| pulse_sel | input | 1 | Rate-mode clk_en form: 0 toggle, 1 strobe |
| preset_wr | input | 1 | Store preset_data into the preset register |
| preset_data | input | 16 | Preset value |
| start | input | 1 | Load the counter and begin |
| stop | input | 1 | Halt and hold the count |
| tick_in | input | 1 | Reference tick (rate, delay, measure) |
| evt_in | input | 1 | External event line, rising edges counted |
| char_done | input | 1 | One-cycle strobe per serial character |
| ser_in | input | 1 | Serial input whose bit length is measured |
| count | output | 16 | Current counter value |
| running | output | 1 | Counter active |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| frame_end | output | 1 | Character-mode terminal count |
| clk_en | output | 1 | Rate-mode clock enable |
| cap_value | output | 16 | Last measured bit length |
| cap_valid | output | 1 | A measurement has completed since start |
| cap_ovf | output | 1 | Measurement saturated |

## Verification
The assertions check several rules on every cycle. A stopped counter must hold its value. A delay-mode terminal count must leave the counter at zero and stopped. A rate-mode terminal count must keep the counter running. frame_end may appear only with tc_pulse, and a saturated measurement must sit at 0xFFFF. Other behaviour needs the bench's scenarios to show it: the exact terminal-count spacing for a given preset, the clk_en toggle versus strobe forms, edge-only counting in event mode, the tick total between two serial edges, and saturation after more than 65535 ticks.

// File: rtl/mf_counter_timer.sv
module mf_counter_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode_sel,
  input  logic         pulse_sel,
  input  logic         preset_wr,
  input  logic [W-1:0] preset_data,
  input  logic         start,
  input  logic         stop,
  input  logic         tick_in,
  input  logic         evt_in,
  input  logic         char_done,
  input  logic         ser_in,
  output logic [W-1:0] count,
  output logic         running,
  output logic         tc_pulse,
  output logic         frame_end,
  output logic         clk_en,
  output logic [W-1:0] cap_value,
  output logic         cap_valid,
  output logic         cap_ovf
);
  localparam logic [2:0] M_RATE  = 3'd0;
  localparam logic [2:0] M_EVENT = 3'd1;
  localparam logic [2:0] M_CHAR  = 3'd2;
  localparam logic [2:0] M_DELAY = 3'd3;
  localparam logic [2:0] M_MEAS  = 3'd4;
  localparam logic [W-1:0] FULL  = '1;

  logic [W-1:0] cnt_q, pre_q, cap_q;
  logic run_q, tc_q, fe_q, ce_q, vld_q, ovf_q, armed_q, evt_q, ser_q;
  logic dec, last, ser_edge;

  assign ser_edge = ser_in ^ ser_q;
  assign last     = (cnt_q[W-1:1] == '0);

  always_comb begin
    case (mode_sel)
      M_RATE, M_DELAY: dec = tick_in;
      M_EVENT:         dec = evt_in & ~evt_q;
      M_CHAR:          dec = char_done;
      default:         dec = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pre_q   <= '0;
      cap_q   <= '0;
      run_q   <= 1'b0;
      tc_q    <= 1'b0;
      fe_q    <= 1'b0;
      ce_q    <= 1'b0;
      vld_q   <= 1'b0;
      ovf_q   <= 1'b0;
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
      ser_q   <= 1'b0;
    end else begin
      evt_q <= evt_in;
      ser_q <= ser_in;
      tc_q  <= 1'b0;
      fe_q  <= 1'b0;
      if (pulse_sel) ce_q <= 1'b0;
      if (preset_wr) pre_q <= preset_data;
      if (start) begin
        run_q   <= 1'b1;
        vld_q   <= 1'b0;
        ovf_q   <= 1'b0;
        ce_q    <= 1'b0;
        armed_q <= 1'b0;
        cnt_q   <= (mode_sel == M_MEAS) ? '0 : pre_q;
      end else if (stop) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        if (mode_sel == M_MEAS) begin
          if (ser_edge) begin
            if (!armed_q) begin
              armed_q <= 1'b1;
              cnt_q   <= '0;
            end else begin
              cap_q <= cnt_q;
              vld_q <= 1'b1;
              run_q <= 1'b0;
            end
          end else if (armed_q && tick_in) begin
            if (cnt_q == FULL) ovf_q <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
          end
        end else if (dec) begin
          if (last) begin
            tc_q <= 1'b1;
            fe_q <= (mode_sel == M_CHAR);
            if (mode_sel == M_DELAY) begin
              cnt_q <= '0;
              run_q <= 1'b0;
            end else begin
              cnt_q <= pre_q;
            end
            if (mode_sel == M_RATE) ce_q <= pulse_sel ? 1'b1 : ~ce_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign count     = cnt_q;
  assign running   = run_q;
  assign tc_pulse  = tc_q;
  assign frame_end = fe_q;
  assign clk_en    = (mode_sel == M_RATE) & ce_q;
  assign cap_value = cap_q;
  assign cap_valid = vld_q;
  assign cap_ovf   = ovf_q;
endmodule

// File: rtl/mf_counter_timer_sva.sv
module mf_counter_timer_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   mode_sel,
  input logic         start,
  input logic [W-1:0] count,
  input logic         running,
  input logic         tc_pulse,
  input logic         frame_end,
  input logic         cap_valid,
  input logic         cap_ovf
);
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));

  a_r3_rate_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && mode_sel == 3'd0) |-> running);

  a_r6_frame_with_tc: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (tc_pulse && mode_sel == 3'd2));

  a_r7_delay_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && mode_sel == 3'd3) |-> (!running && count == '0));

  a_r8_capture_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_valid) |-> !running);

  a_r9_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ovf && running && mode_sel == 3'd4) |-> (count == '1));
endmodule

bind mf_counter_timer mf_counter_timer_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .start(start),
  .count(count), .running(running), .tc_pulse(tc_pulse),
  .frame_end(frame_end), .cap_valid(cap_valid), .cap_ovf(cap_ovf)
);

// File: tb/mf_counter_timer_tb.sv
`timescale 1ns/1ps
module mf_counter_timer_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode_sel = 0;
  logic pulse_sel = 0, preset_wr = 0, start = 0, stop = 0;
  logic tick_in = 0, evt_in = 0, char_done = 0, ser_in = 0;
  logic [15:0] preset_data = 0;
  logic [15:0] count, cap_value;
  logic running, tc_pulse, frame_end, clk_en, cap_valid, cap_ovf;

  mf_counter_timer u_dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    int          due;
    string       req;
    logic        fe;
    logic [15:0] cnt;
    logic        ce;
  } exp_t;
  exp_t q[$];

  int cyc_n = 0, errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] exp_cnt, exp_pre;
  logic exp_ce;

  always @(posedge clk) cyc_n <= cyc_n + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always begin
    @(posedge clk); #1;
    if (rst_n) begin
      if (tc_pulse) begin
        if (q.size() == 0 || q[0].due != cyc_n) begin
          checks++; errors++;
          $display("FAIL R3: unexpected tc actual=1 expected=0 at cycle %0d", cyc_n);
        end else begin
          chk({q[0].req, " frame_end"}, frame_end, q[0].fe);
          chk({q[0].req, " reload"}, count, q[0].cnt);
          chk({q[0].req, " clk_en"}, clk_en, q[0].ce);
          void'(q.pop_front());
        end
      end else if (q.size() != 0 && q[0].due == cyc_n) begin
        checks++; errors++;
        $display("FAIL %s: tc actual=0 expected=1 at cycle %0d", q[0].req, cyc_n);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  task automatic clk1();
    @(posedge clk); #1;
  endtask

  task automatic wr_preset(input logic [15:0] v);
    preset_wr = 1; preset_data = v; clk1(); preset_wr = 0;
    exp_pre = v;
  endtask

  task automatic do_start(input string req);
    start = 1; clk1(); start = 0;
    exp_cnt = (mode_sel == 3'd4) ? 16'h0 : exp_pre;
    exp_ce = 0;
    chk({req, " start count"}, count, exp_cnt);
    chk({req, " start running"}, running, 1);
  endtask

  task automatic dec_once(input string req);
    exp_t it;
    bit term;
    term = (exp_cnt <= 1);
    if (term) begin
      exp_cnt = (mode_sel == 3'd3) ? 16'h0 : exp_pre;
      if (mode_sel == 3'd0 && !pulse_sel) exp_ce = ~exp_ce;
      it.due = cyc_n + 1; it.req = req; it.fe = (mode_sel == 3'd2);
      it.cnt = exp_cnt; it.ce = (mode_sel == 3'd0) ? (pulse_sel ? 1'b1 : exp_ce) : 1'b0;
      q.push_back(it);
    end else exp_cnt = exp_cnt - 1;
    case (mode_sel)
      3'd0, 3'd3: tick_in = 1;
      3'd1:       evt_in = 1;
      3'd2:       char_done = 1;
      default:    ;
    endcase
    clk1();
    tick_in = 0; char_done = 0;
    chk({req, " count"}, count, exp_cnt);
    if (mode_sel == 3'd1) begin
      clk1();
      chk("R5 held level", count, exp_cnt);
      evt_in = 0; clk1();
      chk("R5 falling edge", count, exp_cnt);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1; clk1();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 running", running, 0);
    chk("R1 tc", tc_pulse, 0);
    chk("R1 clk_en", clk_en, 0);
    chk("R1 cap", {cap_value, cap_valid, cap_ovf}, 0);

    // R3 / R4 rate toggle
    mode_sel = 0; pulse_sel = 0;
    wr_preset(3);
    do_start("R1");
    for (int k = 0; k < 9; k++) begin
      dec_once("R3");
      if (k == 3) begin clk1(); chk("R3 no tick", count, exp_cnt); end
    end
    chk("R4 toggle level", clk_en, 1);

    // R2 stop holds
    stop = 1; clk1(); stop = 0;
    chk("R2 stopped", running, 0);
    tick_in = 1; evt_in = 1; char_done = 1; ser_in = 1;
    repeat (4) clk1();
    tick_in = 0; evt_in = 0; char_done = 0; ser_in = 0; clk1();
    chk("R2 hold", count, exp_cnt);

    // R1 preset written with start uses old preset
    preset_wr = 1; preset_data = 7; start = 1; clk1();
    preset_wr = 0; start = 0;
    chk("R1 same-cycle preset", count, 3);
    exp_pre = 7; exp_cnt = 3; exp_ce = 0;

    // R4 pulse form
    pulse_sel = 1;
    wr_preset(2);
    do_start("R4");
    for (int k = 0; k < 4; k++) begin
      dec_once("R4");
      if (k % 2 == 1) begin clk1(); chk("R4 strobe low after", clk_en, 0); end
    end

    // R5 event mode
    mode_sel = 1; pulse_sel = 0;
    wr_preset(3);
    do_start("R5");
    tick_in = 1; repeat (3) clk1(); tick_in = 0;
    chk("R5 tick ignored", count, exp_cnt);
    chk("R4 clk_en low other mode", clk_en, 0);
    for (int k = 0; k < 6; k++) dec_once("R5");

    // R6 character mode
    mode_sel = 2;
    wr_preset(2);
    do_start("R6");
    for (int k = 0; k < 5; k++) dec_once("R6");

    // R7 delay mode
    mode_sel = 3;
    wr_preset(4);
    do_start("R7");
    for (int k = 0; k < 4; k++) dec_once("R7");
    chk("R7 stopped", running, 0);
    tick_in = 1; repeat (5) clk1(); tick_in = 0; clk1();
    chk("R7 stays zero", count, 0);

    // R10 idle mode
    mode_sel = 5;
    wr_preset(9);
    do_start("R10");
    tick_in = 1; char_done = 1; evt_in = 1; repeat (3) clk1();
    tick_in = 0; char_done = 0; evt_in = 0; clk1();
    chk("R10 idle count", count, 9);

    // R8 measurement
    mode_sel = 4; ser_in = 0; clk1();
    do_start("R8");
    tick_in = 1; repeat (3) clk1(); tick_in = 0;
    chk("R8 waits for edge", count, 0);
    ser_in = 1; clk1();
    for (int k = 0; k < 10; k++) begin tick_in = (k % 3 != 1); clk1(); end
    tick_in = 0;
    chk("R8 running count", count, 7);
    ser_in = 0; clk1();
    chk("R8 cap_value", cap_value, 7);
    chk("R8 cap_valid", cap_valid, 1);
    chk("R8 stopped", running, 0);
    chk("R9 no overflow", cap_ovf, 0);

    // R9 saturation
    do_start("R9");
    chk("R9 start clears valid", cap_valid, 0);
    ser_in = 1; clk1();
    tick_in = 1; repeat (65540) clk1(); tick_in = 0;
    chk("R9 saturated count", count, 16'hFFFF);
    chk("R9 overflow flag", cap_ovf, 1);
    ser_in = 0; clk1();
    chk("R9 cap saturated", cap_value, 16'hFFFF);
    chk("R9 ovf held", cap_ovf, 1);
    do_start("R9");
    chk("R9 start clears ovf", cap_ovf, 0);

    clk1();
    chk("R3 all expected tc seen", q.size(), 0);
    finish_up();
  end
endmodule